// File: doc/BRIEF.md
# Extended memory bank address mapper

This block sits between an 8-bit CPU address bus and a 128 KB static RAM. It produces the three upper SRAM address lines. Most of the time the lower 64 KB of the SRAM acts as plain base memory. The 16 KB region at 0x4000–0x7FFF can instead be redirected into one of four 16 KB banks in the upper 64 KB. Two control port bits enable this redirection: one for processor accesses and one for video DMA accesses. Two further port bits choose the bank. Bank number n maps to SRAM offset 0x10000 + n × 0x4000.

Video DMA accesses are redirected only while the DMA engine is holding the CPU off the bus. The block does not trust the live halt line for this decision. It keeps a one-bit halt state that is refreshed from the halt line once per bus cycle, shortly after the phase clock falls.

The phase clock arrives as an ordinary input. It is sampled by a faster system clock, so the capture is delayed by a few system-clock cycles. The outputs are combinational from the address bits, the port bits and the stored halt state. The second SRAM chip enable is tied active.

Top module: `bank_window_mapper`

## Requirements
- R1: When the access is outside the window (cpu_a14=0 or cpu_a15=1), sram_a equals {1'b0, cpu_a15, cpu_a14}, whatever the port bits and the halt state are.
- R2: When cpu_bank_n=1 and vid_bank_n=1, sram_a equals {1'b0, cpu_a15, cpu_a14} for every address, so the SRAM behaves as flat 64 KB.
- R3: Take an in-window access (cpu_a14=1, cpu_a15=0) with cpu_bank_n=0 and vid_bank_n=1. Then sram_a[2]=1, sram_a[1]=bank_sel[1] and sram_a[0]=bank_sel[0], for all four bank numbers.
- R4: Take an in-window access with vid_bank_n=0 and cpu_bank_n=1 while the stored halt state is active. Then sram_a = {1'b1, bank_sel}, for all four bank numbers.
- R5: Take an in-window access with vid_bank_n=0 and cpu_bank_n=1 while the stored halt state is inactive. Then sram_a = 3'b001.
- R6: The halt state takes the value of !halt_n at the second system-clock edge after the edge that first sees phase_clk low following a high sample. At any other time halt_n has no effect on sram_a.
- R7: With both cpu_bank_n=0 and vid_bank_n=0, an in-window access is banked ({1'b1, bank_sel}), whether the stored halt state is active or inactive.
- R8: Reset (rst_n=0) clears the stored halt state to inactive.
- R9: sram_ce2 is 1 at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the phase clock |
| rst_n | input | 1 | Active-low reset |
| cpu_a14 | input | 1 | CPU address bit 14 |
| cpu_a15 | input | 1 | CPU address bit 15 |
| bank_sel | input | 2 | Bank number; bit 0 drives sram_a[0], bit 1 drives sram_a[1] when banked |
| cpu_bank_n | input | 1 | Active-low enable of banking for CPU accesses |
| vid_bank_n | input | 1 | Active-low enable of banking for video DMA accesses |
| halt_n | input | 1 | Active-low CPU halt from the video DMA engine |
| phase_clk | input | 1 | Bus phase-2 clock, sampled synchronously |
| sram_a | output | 3 | SRAM address bits 16:14 |
| sram_ce2 | output | 1 | Second SRAM chip enable, constant high |

## Verification
The hardest situation to reach is a halt_n change that the block must ignore. halt_n has to move while phase_clk stays level, and the mapped address has to expose the stored halt state. The bench reaches it in several steps. It first sets the block to video-only banking with an in-window address. It then holds phase_clk high and toggles halt_n, and confirms that sram_a does not move. Finally it drops phase_clk and counts the system-clock edges until the banked address appears. The same check is repeated after the capture, with halt_n changing while phase_clk stays low.

// File: rtl/bwm_pkg.sv
package bwm_pkg;

    // Value the stored halt state takes out of reset: not halted.
    localparam logic HALT_IDLE = 1'b0;

    // Per-access selection result of the window decoder.
    typedef struct packed {
        logic in_window;
        logic cpu_hit;
        logic vid_hit;
    } map_sel_t;

endpackage

// File: rtl/phase_fall_detect.sv
module phase_fall_detect #(
    parameter int SYNC_STAGES  = 2,
    parameter int DELAY_STAGES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic phase_in,
    output logic fall_strobe
);
    localparam int SW = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;
    localparam int DW = (DELAY_STAGES < 1) ? 1 : DELAY_STAGES;

    typedef struct packed {
        logic [SW-1:0] sync;
        logic [DW-1:0] dly;
    } pfd_state_t;

    pfd_state_t st_d, st_q;
    logic       edge_seen;

    always_comb begin
        st_d      = st_q;
        edge_seen = st_q.sync[SW-1] & ~st_q.sync[SW-2];
        st_d.sync = {st_q.sync[SW-2:0], phase_in};
        st_d.dly[0] = edge_seen;
    end

    generate
        if (DW > 1) begin : g_delay_chain
            for (genvar i = 1; i < DW; i++) begin : g_stage
                assign st_d_dly_shift[i] = st_q.dly[i-1];
            end
        end
    endgenerate

    logic [DW-1:0] st_d_dly_shift;
    assign st_d_dly_shift[0] = 1'b0;

    pfd_state_t st_n;
    always_comb begin
        st_n = st_d;
        for (int k = 1; k < DW; k++) begin
            st_n.dly[k] = st_d_dly_shift[k];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_n;
        end
    end

    assign fall_strobe = st_q.dly[DW-1];

endmodule

// File: rtl/halt_capture.sv
module halt_capture
    import bwm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic halt_n,
    output logic halted
);
    logic halted_d, halted_q;

    always_comb begin
        halted_d = halted_q;
        if (strobe) begin
            halted_d = ~halt_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            halted_q <= HALT_IDLE;
        end else begin
            halted_q <= halted_d;
        end
    end

    assign halted = halted_q;

endmodule

// File: rtl/window_map.sv
module window_map
    import bwm_pkg::*;
#(
    parameter int BANK_BITS = 2
) (
    input  logic                 a14,
    input  logic                 a15,
    input  logic [BANK_BITS-1:0] bank_sel,
    input  logic                 cpu_bank_n,
    input  logic                 vid_bank_n,
    input  logic                 halted,
    output logic [BANK_BITS:0]   sram_hi
);
    map_sel_t sel;
    logic     banked;

    always_comb begin
        sel.in_window = a14 & ~a15;
        sel.cpu_hit   = sel.in_window & ~cpu_bank_n & ~halted;
        sel.vid_hit   = sel.in_window & ~vid_bank_n & halted;
        // CPU banking also holds while halted if only the CPU enable is set
        banked = sel.cpu_hit | sel.vid_hit | (sel.in_window & ~cpu_bank_n & vid_bank_n);
        sram_hi = '0;
        if (banked) begin
            sram_hi = {1'b1, bank_sel};
        end else begin
            sram_hi[0] = a14;
            sram_hi[1] = a15;
        end
    end

endmodule

// File: rtl/bank_window_mapper.sv
module bank_window_mapper #(
    parameter int BANK_BITS    = 2,
    parameter int SYNC_STAGES  = 2,
    parameter int DELAY_STAGES = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cpu_a14,
    input  logic                 cpu_a15,
    input  logic [BANK_BITS-1:0] bank_sel,
    input  logic                 cpu_bank_n,
    input  logic                 vid_bank_n,
    input  logic                 halt_n,
    input  logic                 phase_clk,
    output logic [BANK_BITS:0]   sram_a,
    output logic                 sram_ce2
);
    logic fall_strobe;
    logic halted;

    phase_fall_detect #(
        .SYNC_STAGES (SYNC_STAGES),
        .DELAY_STAGES(DELAY_STAGES)
    ) u_fall (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase_in   (phase_clk),
        .fall_strobe(fall_strobe)
    );

    halt_capture u_halt (
        .clk   (clk),
        .rst_n (rst_n),
        .strobe(fall_strobe),
        .halt_n(halt_n),
        .halted(halted)
    );

    window_map #(
        .BANK_BITS(BANK_BITS)
    ) u_map (
        .a14       (cpu_a14),
        .a15       (cpu_a15),
        .bank_sel  (bank_sel),
        .cpu_bank_n(cpu_bank_n),
        .vid_bank_n(vid_bank_n),
        .halted    (halted),
        .sram_hi   (sram_a)
    );

    assign sram_ce2 = 1'b1;

endmodule

// File: rtl/bank_window_mapper_chk.sv
module bank_window_mapper_chk #(
    parameter int BANK_BITS = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cpu_a14,
    input logic                 cpu_a15,
    input logic [BANK_BITS-1:0] bank_sel,
    input logic                 cpu_bank_n,
    input logic                 vid_bank_n,
    input logic                 halt_n,
    input logic                 phase_clk,
    input logic [BANK_BITS:0]   sram_a,
    input logic                 sram_ce2
);
    logic [2:0] cyc_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q <= '0;
        end else if (cyc_q != 3'd7) begin
            cyc_q <= cyc_q + 3'd1;
        end
    end

    logic in_win;
    assign in_win = cpu_a14 & ~cpu_a15;

    // R1
    outside_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_win |-> (sram_a[BANK_BITS] == 1'b0 && sram_a[1] == cpu_a15 && sram_a[0] == cpu_a14));

    // R2
    flat_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_bank_n && vid_bank_n) |-> (sram_a[BANK_BITS] == 1'b0 && sram_a[0] == cpu_a14));

    // R3
    cpu_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_win && !cpu_bank_n && vid_bank_n) |-> (sram_a == {1'b1, bank_sel}));

    // R7
    both_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_win && !cpu_bank_n && !vid_bank_n) |-> (sram_a == {1'b1, bank_sel}));

    // R6
    live_halt_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q >= 3'd4 && phase_clk && $past(phase_clk) && $past(phase_clk, 2) && $past(phase_clk, 3)
         && $stable(cpu_a14) && $stable(cpu_a15) && $stable(cpu_bank_n) && $stable(vid_bank_n)
         && $stable(bank_sel)) |-> $stable(sram_a));

    // R8
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q == 3'd0 && in_win && cpu_bank_n && !vid_bank_n) |-> (sram_a[BANK_BITS] == 1'b0));

    // R9
    ce2_high_chk: assert property (@(posedge clk) disable iff (!rst_n) sram_ce2 == 1'b1);

endmodule

bind bank_window_mapper bank_window_mapper_chk #(.BANK_BITS(BANK_BITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_a14   (cpu_a14),
    .cpu_a15   (cpu_a15),
    .bank_sel  (bank_sel),
    .cpu_bank_n(cpu_bank_n),
    .vid_bank_n(vid_bank_n),
    .halt_n    (halt_n),
    .phase_clk (phase_clk),
    .sram_a    (sram_a),
    .sram_ce2  (sram_ce2)
);

// File: tb/bank_window_mapper_bench.sv
module bank_window_mapper_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_a14 = 1'b0;
    logic       cpu_a15 = 1'b0;
    logic [1:0] bank_sel = 2'b00;
    logic       cpu_bank_n = 1'b1;
    logic       vid_bank_n = 1'b1;
    logic       halt_n = 1'b1;
    logic       phase_clk = 1'b1;
    logic [2:0] sram_a;
    logic       sram_ce2;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bank_window_mapper u_bank_window_mapper (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_a14   (cpu_a14),
        .cpu_a15   (cpu_a15),
        .bank_sel  (bank_sel),
        .cpu_bank_n(cpu_bank_n),
        .vid_bank_n(vid_bank_n),
        .halt_n    (halt_n),
        .phase_clk (phase_clk),
        .sram_a    (sram_a),
        .sram_ce2  (sram_ce2)
    );

    // {req[3:0], halt, a15, a14, bank[1], bank[0], cpu_n, vid_n, exp[2:0]}
    localparam int NV = 18;
    localparam logic [13:0] VEC [NV] = '{
        {4'd1, 1'b0, 1'b0, 1'b0, 2'b11, 1'b0, 1'b0, 3'b000}, // R1 low region
        {4'd1, 1'b0, 1'b1, 1'b1, 2'b10, 1'b0, 1'b1, 3'b011}, // R1 top region
        {4'd1, 1'b0, 1'b1, 1'b0, 2'b01, 1'b1, 1'b1, 3'b010}, // R1 0x8000 region
        {4'd2, 1'b0, 1'b0, 1'b1, 2'b11, 1'b1, 1'b1, 3'b001}, // R2 flat window
        {4'd3, 1'b0, 1'b0, 1'b1, 2'b00, 1'b0, 1'b1, 3'b100}, // R3 bank 0
        {4'd3, 1'b0, 1'b0, 1'b1, 2'b01, 1'b0, 1'b1, 3'b101}, // R3 bank 1
        {4'd3, 1'b0, 1'b0, 1'b1, 2'b10, 1'b0, 1'b1, 3'b110}, // R3 bank 2
        {4'd3, 1'b0, 1'b0, 1'b1, 2'b11, 1'b0, 1'b1, 3'b111}, // R3 bank 3
        {4'd5, 1'b0, 1'b0, 1'b1, 2'b11, 1'b1, 1'b0, 3'b001}, // R5 video, not halted
        {4'd4, 1'b1, 1'b0, 1'b1, 2'b00, 1'b1, 1'b0, 3'b100}, // R4 bank 0
        {4'd4, 1'b1, 1'b0, 1'b1, 2'b01, 1'b1, 1'b0, 3'b101}, // R4 bank 1
        {4'd4, 1'b1, 1'b0, 1'b1, 2'b10, 1'b1, 1'b0, 3'b110}, // R4 bank 2
        {4'd4, 1'b1, 1'b0, 1'b1, 2'b11, 1'b1, 1'b0, 3'b111}, // R4 bank 3
        {4'd7, 1'b1, 1'b0, 1'b1, 2'b10, 1'b0, 1'b0, 3'b110}, // R7 halted
        {4'd7, 1'b0, 1'b0, 1'b1, 2'b01, 1'b0, 1'b0, 3'b101}, // R7 not halted
        {4'd1, 1'b1, 1'b0, 1'b0, 2'b11, 1'b1, 1'b0, 3'b000}, // R1 halted, outside
        {4'd1, 1'b1, 1'b1, 1'b0, 2'b11, 1'b0, 1'b0, 3'b010}, // R1 halted, outside
        {4'd2, 1'b1, 1'b0, 1'b1, 2'b11, 1'b1, 1'b1, 3'b001}  // R2 halted, flat
    };

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: sram_a=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic wait_edges(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Drive halt_n, then complete one phase high/low cycle so it is captured.
    task automatic load_halt(input logic h);
        @(negedge clk);
        halt_n = ~h;
        phase_clk = 1'b1;
        wait_edges(3);
        phase_clk = 1'b0;
        wait_edges(4);
    endtask

    task automatic video_window();
        cpu_a14 = 1'b1;
        cpu_a15 = 1'b0;
        cpu_bank_n = 1'b1;
        vid_bank_n = 1'b0;
        bank_sel = 2'b10;
    endtask

    initial begin
        wait_edges(3);
        // R8 reset state, with the live halt asserted while in reset
        video_window();
        halt_n = 1'b0;
        @(negedge clk);
        check("R8", sram_a, 3'b001);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8", sram_a, 3'b001);
        check("R9", {2'b00, sram_ce2}, 3'b001);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            load_halt(VEC[v][9]);
            cpu_a15 = VEC[v][8];
            cpu_a14 = VEC[v][7];
            bank_sel = VEC[v][6:5];
            cpu_bank_n = VEC[v][4];
            vid_bank_n = VEC[v][3];
            @(negedge clk);
            check($sformatf("R%0d vec%0d", VEC[v][13:10], v), sram_a, VEC[v][2:0]);
        end

        // R6: live halt ignored while phase stays high
        load_halt(1'b0);
        video_window();
        phase_clk = 1'b1;
        wait_edges(4);
        halt_n = 1'b0;
        wait_edges(5);
        check("R6 halt while phase high", sram_a, 3'b001);
        // Falling phase: capture lands on the second edge after the low sample
        phase_clk = 1'b0;
        @(negedge clk);   // edge 1 sees low
        check("R6 before capture", sram_a, 3'b001);
        @(negedge clk);   // edge 2: delayed strobe
        check("R6 before capture", sram_a, 3'b001);
        @(negedge clk);   // edge 3: stored
        check("R6 captured", sram_a, 3'b110);
        // Live halt released while phase stays low: no effect
        halt_n = 1'b1;
        wait_edges(5);
        check("R6 release while phase low", sram_a, 3'b110);
        check("R9", {2'b00, sram_ce2}, 3'b001);

        // R8: reset clears a stored halt
        rst_n = 1'b0;
        halt_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 reset clears halt", sram_a, 3'b001);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                failures++;
                checks++;
                $display("FAIL watchdog: run did not finish");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule